// File: doc/BRIEF.md
# Register-File OR Execute Stage

This block carries out one single-word instruction: a bitwise OR of an 8-bit working register with one byte taken from a 256-entry register file. Each instruction cycle is cut into four phases. The first phase captures and decodes the instruction word. The second phase reads the addressed file byte. The third phase forms the OR result. The fourth phase writes that result to its destination and updates the zero flag.

One bit of the instruction selects the destination. The result goes either to the working register or back into the file byte it came from. Any other instruction word is accepted in the decode phase and then behaves as a no-op for the whole cycle. The register file is outside the block. The block drives its address, write data and write enable, and the file returns read data combinationally. The current phase is brought out so that the instruction supplier can present each new word in the decode phase.

The phase sequencer is a four-state machine. Its states are DECODE, FETCH, CALC and COMMIT. It follows the transitions DECODE to FETCH, FETCH to CALC, CALC to COMMIT and COMMIT to DECODE on every clock, and reset puts it in DECODE.

Top module: `orx_exec_stage`

## Requirements
- R1: `phase_o` is 0 (DECODE) after reset and steps 0, 1, 2, 3, 0, ... once per clock.
- R2: `instr_i` is captured only on the clock edge that ends phase 0; its value in phases 1 to 3 has no effect.
- R3: A word is executed only when bits [15:9] equal 7'b0000100. Any other word changes no output or file byte, and `rf_we_o` stays low.
- R4: During phases 1, 2 and 3, `rf_addr_o` holds the file address from bits [7:0] of the captured word.
- R5: The result is the bitwise OR of the working register and the file byte at that address.
- R6: With bit 8 (destination) at 0, the result is loaded into `wreg_o` at the end of phase 3, and no file write happens.
- R7: With bit 8 at 1, `rf_we_o` is high only during phase 3 with `rf_wdata_o` equal to the result, and `wreg_o` keeps its value.
- R8: `zflag_o` changes only at the end of phase 3 of an executed word. It becomes 1 exactly when the 8-bit result is 0.
- R9: During reset, `wreg_o` is 0, `zflag_o` is 0 and `rf_we_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word, sampled in phase 0 |
| phase_o | output | 2 | Current phase, 0 to 3 |
| rf_addr_o | output | 8 | Register-file address |
| rf_rdata_i | input | 8 | Register-file read data |
| rf_wdata_o | output | 8 | Register-file write data |
| rf_we_o | output | 1 | Register-file write enable |
| wreg_o | output | 8 | Working register |
| zflag_o | output | 1 | Zero flag |

## Verification
A phase counter that skips or repeats a state shows up on `phase_o` at the very next clock. It also moves the file write strobe away from phase 3 within one instruction cycle. A wrong latched instruction, operand or result reaches the ports no later than the end of the next phase 3, through `wreg_o`, `zflag_o` or the file write data. A reference model stepped on every clock compares all of these outputs at every cycle. The program includes zero results, both destinations, the highest file address, illegal words next to the legal opcode, and junk on the instruction input outside phase 0.

// File: rtl/orx_pkg.sv
package orx_pkg;
    typedef enum logic [1:0] {
        PH_DECODE = 2'd0,
        PH_FETCH  = 2'd1,
        PH_CALC   = 2'd2,
        PH_COMMIT = 2'd3
    } phase_e;

    localparam int OPC_W = 7;
    localparam logic [OPC_W-1:0] OPC_OR_F = 7'b0000100;
endpackage

// File: rtl/orx_phase_seq.sv
module orx_phase_seq
    import orx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase,
    output logic   st_decode,
    output logic   st_fetch,
    output logic   st_calc,
    output logic   st_commit
);
    phase_e state_q;
    phase_e state_d;

    always_comb begin
        unique case (state_q)
            PH_DECODE: state_d = PH_FETCH;
            PH_FETCH:  state_d = PH_CALC;
            PH_CALC:   state_d = PH_COMMIT;
            PH_COMMIT: state_d = PH_DECODE;
            default:   state_d = PH_DECODE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_DECODE;
        else        state_q <= state_d;
    end

    always_comb begin
        st_decode = 1'b0;
        st_fetch  = 1'b0;
        st_calc   = 1'b0;
        st_commit = 1'b0;
        unique case (state_q)
            PH_DECODE: st_decode = 1'b1;
            PH_FETCH:  st_fetch  = 1'b1;
            PH_CALC:   st_calc   = 1'b1;
            PH_COMMIT: st_commit = 1'b1;
            default:   st_decode = 1'b0;
        endcase
    end

    assign phase = state_q;
endmodule

// File: rtl/orx_decoder.sv
module orx_decoder
    import orx_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int INSTR_W = OPC_W + 1 + ADDR_W
) (
    input  logic [INSTR_W-1:0] word,
    output logic               is_or,
    output logic               to_file,
    output logic [ADDR_W-1:0]  faddr
);
    localparam int DST_BIT = ADDR_W;

    assign is_or   = (word[INSTR_W-1 -: OPC_W] == OPC_OR_F);
    assign to_file = word[DST_BIT];
    assign faddr   = word[ADDR_W-1:0];
endmodule

// File: rtl/orx_datapath.sv
module orx_datapath #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_decode,
    input  logic              st_fetch,
    input  logic              st_calc,
    input  logic              st_commit,
    input  logic              dec_is_or,
    input  logic              dec_to_file,
    input  logic [ADDR_W-1:0] dec_faddr,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              rf_we,
    output logic [DATA_W-1:0] wreg,
    output logic              zflag
);
    logic              live_q;
    logic              to_file_q;
    logic [ADDR_W-1:0] faddr_q;
    logic [DATA_W-1:0] opnd_q;
    logic [DATA_W-1:0] res_q;
    logic [DATA_W-1:0] wreg_q;
    logic              z_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q    <= 1'b0;
            to_file_q <= 1'b0;
            faddr_q   <= '0;
            opnd_q    <= '0;
            res_q     <= '0;
            wreg_q    <= '0;
            z_q       <= 1'b0;
        end else begin
            if (st_decode) begin
                live_q    <= dec_is_or;
                to_file_q <= dec_to_file;
                faddr_q   <= dec_faddr;
            end
            if (st_fetch) opnd_q <= rf_rdata;
            if (st_calc)  res_q  <= wreg_q | opnd_q;
            if (st_commit && live_q) begin
                if (!to_file_q) wreg_q <= res_q;
                z_q <= (res_q == '0);
            end
        end
    end

    assign rf_addr  = faddr_q;
    assign rf_wdata = res_q;
    assign rf_we    = st_commit & live_q & to_file_q;
    assign wreg     = wreg_q;
    assign zflag    = z_q;
endmodule

// File: rtl/orx_exec_stage.sv
module orx_exec_stage
    import orx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 8,
    parameter int INSTR_W = OPC_W + 1 + ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    output logic [1:0]         phase_o,
    output logic [ADDR_W-1:0]  rf_addr_o,
    input  logic [DATA_W-1:0]  rf_rdata_i,
    output logic [DATA_W-1:0]  rf_wdata_o,
    output logic               rf_we_o,
    output logic [DATA_W-1:0]  wreg_o,
    output logic               zflag_o
);
    phase_e            phase;
    logic              st_decode, st_fetch, st_calc, st_commit;
    logic              dec_is_or, dec_to_file;
    logic [ADDR_W-1:0] dec_faddr;

    orx_phase_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .st_decode (st_decode),
        .st_fetch  (st_fetch),
        .st_calc   (st_calc),
        .st_commit (st_commit)
    );

    orx_decoder #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_dec (
        .word    (instr_i),
        .is_or   (dec_is_or),
        .to_file (dec_to_file),
        .faddr   (dec_faddr)
    );

    orx_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .st_decode   (st_decode),
        .st_fetch    (st_fetch),
        .st_calc     (st_calc),
        .st_commit   (st_commit),
        .dec_is_or   (dec_is_or),
        .dec_to_file (dec_to_file),
        .dec_faddr   (dec_faddr),
        .rf_rdata    (rf_rdata_i),
        .rf_addr     (rf_addr_o),
        .rf_wdata    (rf_wdata_o),
        .rf_we       (rf_we_o),
        .wreg        (wreg_o),
        .zflag       (zflag_o)
    );

    assign phase_o = phase;
endmodule

// File: rtl/orx_exec_checker.sv
module orx_exec_checker #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        phase_o,
    input logic [ADDR_W-1:0] rf_addr_o,
    input logic              rf_we_o,
    input logic [DATA_W-1:0] wreg_o,
    input logic              zflag_o
);
    assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 2'd3) |=> (phase_o == $past(phase_o) + 2'd1));

    assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd3) |=> (phase_o == 2'd0));

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd2 || phase_o == 2'd3) |-> $stable(rf_addr_o));

    assert_wreg_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 2'd3) |=> $stable(wreg_o));

    assert_we_commit_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> (phase_o == 2'd3));

    assert_file_dest_keeps_wreg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |=> $stable(wreg_o));

    assert_zflag_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 2'd3) |=> $stable(zflag_o));
endmodule

bind orx_exec_stage orx_exec_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_orx_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_o   (phase_o),
    .rf_addr_o (rf_addr_o),
    .rf_we_o   (rf_we_o),
    .wreg_o    (wreg_o),
    .zflag_o   (zflag_o)
);

// File: tb/test_orx_exec_stage.sv
`timescale 1ns/1ps
module test_orx_exec_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr_i = 16'h0000;
    logic [1:0]  phase_o;
    logic [7:0]  rf_addr_o, rf_rdata_i, rf_wdata_o, wreg_o;
    logic        rf_we_o, zflag_o;

    int total = 0;
    int bad = 0;

    logic [7:0] fmem [256];
    logic [7:0] mmem [256];

    always #2.5 clk = ~clk;

    orx_exec_stage i_orx_exec_stage (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .phase_o(phase_o),
        .rf_addr_o(rf_addr_o), .rf_rdata_i(rf_rdata_i), .rf_wdata_o(rf_wdata_o),
        .rf_we_o(rf_we_o), .wreg_o(wreg_o), .zflag_o(zflag_o)
    );

    assign rf_rdata_i = fmem[rf_addr_o];
    always @(posedge clk) if (rf_we_o) fmem[rf_addr_o] <= rf_wdata_o;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] prog[$];
        int ph = 0;
        logic mlive = 1'b0, mdst = 1'b0;
        logic [7:0] mf = 8'h00, mwreg = 8'h00, mres = 8'h00;
        logic mz = 1'b0;
        int drain = 0;

        for (int i = 0; i < 256; i++) begin fmem[i] = 8'h00; mmem[i] = 8'h00; end
        fmem[8'h20] = 8'h91; fmem[8'h21] = 8'h13; fmem[8'h22] = 8'h04;
        fmem[8'hFF] = 8'h40; fmem[8'h00] = 8'h55;
        for (int i = 0; i < 256; i++) mmem[i] = fmem[i];

        prog = '{16'h0810, 16'h0911, 16'hFFFF, 16'h0820, 16'h0821, 16'h0922,
                 16'h0A22, 16'h0822, 16'h1222, 16'h09FF, 16'h0800, 16'h08FF};

        repeat (3) @(negedge clk);
        // R9: reset values
        chk("R9 wreg", wreg_o, 0);
        chk("R9 zflag", zflag_o, 0);
        chk("R9 we", rf_we_o, 0);
        chk("R1 reset phase", phase_o, 0);
        rst_n = 1'b1;

        while (prog.size() > 0 || drain < 8) begin
            chk("R1 phase", phase_o, ph);
            chk("R5 R6 R2 R3 wreg", wreg_o, mwreg);
            chk("R8 zflag", zflag_o, mz);
            chk("R7 R3 write enable", rf_we_o, (ph == 3 && mlive && mdst) ? 1 : 0);
            if (ph != 0 && mlive) chk("R4 address", rf_addr_o, mf);
            if (ph == 3 && mlive && mdst) chk("R7 write data", rf_wdata_o, mwreg | mmem[mf]);

            if (ph == 0) begin
                if (prog.size() > 0) instr_i = prog.pop_front();
                else begin instr_i = 16'hFFFF; drain++; end
                mlive = (instr_i[15:9] == 7'b0000100);
                mdst  = instr_i[8];
                mf    = instr_i[7:0];
            end else begin
                // R2: junk outside the decode phase must be ignored
                instr_i = 16'(($urandom() & 32'hFFFF));
            end

            if (ph == 3 && mlive) begin
                mres = mwreg | mmem[mf];
                if (mdst) mmem[mf] = mres;
                else      mwreg = mres;
                mz = (mres == 8'h00);
            end
            ph = (ph + 1) % 4;
            @(negedge clk);
        end

        chk("R6 file untouched on d=0", fmem[8'h21], 8'h13);
        chk("R7 file written on d=1", fmem[8'h22], 8'h97);
        chk("R7 top address written", fmem[8'hFF], 8'hD7);
        chk("R7 zero written back", fmem[8'h11], 8'h00);
        chk("R5 final wreg", wreg_o, 8'hD7);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule